// File: doc/BRIEF.md
# Adaptive Serializing Fault-Tolerant Link

This block carries fixed-width words across a parallel bundle of inter-die wires, some of which may be defective. A per-wire health vector, produced earlier by an interconnect test, is latched on a configure strobe while the link is idle. Data bits are then packed in order onto the healthy wires only. When fewer healthy wires exist than data bits, each word is sent over several consecutive beats and rebuilt at the receiving end.

The transmitter and the receiver both live in this module and share the latched health vector, so they always agree on the mapping. The wire bundle leaves the block on `link_tx` and `link_tx_vld` and comes back on `link_rx` and `link_rx_vld`, so the physical crossing, including any corruption on dead wires, sits outside the block. A word is taken on the `tx_valid`/`tx_ready` handshake and delivered on `rx_valid`/`rx_ready`. The transmitter starts a new word only when the receive side has no word pending, so stalls fall only on word boundaries.

Top module: `adaptive_serial_link`

## Requirements
- R1: After reset the latched health vector is all zeros, so `link_failed`=1, `tx_ready`=0, `rx_valid`=0, `busy`=0 and `link_tx_vld`=0.
- R2: `cfg_strobe` latches `diag` (bit w = 1 means wire w is healthy) only while `busy`=0. A strobe while `busy`=1 is ignored and the previous mapping stays in force.
- R3: With H the count of ones in the latched vector, `link_failed`=1 whenever H < MLIMIT. While failed, `tx_ready` stays 0 and no beat is sent.
- R4: A wire marked faulty drives 0 on `link_tx` in every cycle.
- R5: On beat b, the k-th healthy wire in ascending wire index carries data bit b*H+k. A healthy wire whose bit index is N or more, such as an unused position on the last beat, drives 0.
- R6: A word accepted at a clock edge is sent as ceil(N/H) beats, or as 1 beat when H ≥ N. `link_tx_vld` is high for exactly that many consecutive cycles, starting in the cycle after acceptance.
- R7: `rx_valid` rises in the cycle after the final beat, with `rx_data` equal to the sent word. Values on received wires that are marked faulty have no effect.
- R8: While `rx_valid`=1 and `rx_ready`=0, `rx_valid` and `rx_data` hold and `tx_ready` stays 0. No new word starts until the pending one is taken.
- R9: `busy` is high exactly while a word is being sent or a received word is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_strobe | input | 1 | Latch `diag` when idle |
| diag | input | N+R | Wire health vector, 1 = healthy |
| tx_valid | input | 1 | Word offered to transmitter |
| tx_data | input | N | Word to send |
| tx_ready | output | 1 | Transmitter takes the word |
| link_tx | output | N+R | Driven wire bundle |
| link_tx_vld | output | 1 | Beat strobe on the bundle |
| link_rx | input | N+R | Received wire bundle |
| link_rx_vld | input | 1 | Received beat strobe |
| rx_valid | output | 1 | Rebuilt word available |
| rx_data | output | N | Rebuilt word |
| rx_ready | input | 1 | Consumer takes the word |
| link_failed | output | 1 | Too few healthy wires |
| busy | output | 1 | Word in flight or pending |

## Verification
The hardest cases to reach are the uneven splits, where the last beat fills only part of the healthy wires, and a configure strobe that lands while a word is still pending. The bench walks a table of health vectors chosen to give one, two, three and four beats, including four-beat splits whose last beat carries one bit and four bits. It checks every beat against a packing model and sets garbage on the dead wires on the way back. It then holds `rx_ready` low to keep a word pending and fires a strobe carrying a failing vector, which must leave the link working.

// File: rtl/adaptive_serial_link.sv
module adaptive_serial_link #(
  parameter int N = 16,
  parameter int R = 2,
  parameter int MLIMIT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_strobe,
  input  logic [N+R-1:0] diag,
  input  logic         tx_valid,
  input  logic [N-1:0] tx_data,
  output logic         tx_ready,
  output logic [N+R-1:0] link_tx,
  output logic         link_tx_vld,
  input  logic [N+R-1:0] link_rx,
  input  logic         link_rx_vld,
  output logic         rx_valid,
  output logic [N-1:0] rx_data,
  input  logic         rx_ready,
  output logic         link_failed,
  output logic         busy
);
  localparam int W  = N + R;
  localparam int CW = $clog2(W + 1);
  localparam int BW = $clog2(N + 1);

  logic [W-1:0]  cfg;
  logic          sending;
  logic [BW-1:0] tx_beat, rx_beat, nb;
  logic [W-1:0]  tx_sh;
  logic [N-1:0]  acc;
  logic          rx_valid_q;
  logic [N-1:0]  rx_data_q;
  logic [CW-1:0] hcnt;
  logic [CW-1:0] rank [W];
  logic [W-1:0]  gath;
  logic [N+W-1:0] wide;
  logic [N-1:0]  placed;

  always_comb begin
    logic [CW-1:0] c;
    c = '0;
    for (int w = 0; w < W; w++) begin
      rank[w] = c;
      c = c + CW'(cfg[w]);
    end
    hcnt = c;
  end

  always_comb begin
    if (hcnt == 0) nb = BW'(1);
    else nb = BW'((N + int'(hcnt) - 1) / int'(hcnt));
  end

  assign link_failed = hcnt < CW'(MLIMIT);
  assign busy        = sending | rx_valid_q;
  assign tx_ready    = !sending && !rx_valid_q && !link_failed;
  assign link_tx_vld = sending;
  assign rx_valid    = rx_valid_q;
  assign rx_data     = rx_data_q;

  always_comb begin
    for (int w = 0; w < W; w++)
      link_tx[w] = sending & cfg[w] & tx_sh[rank[w]];
  end

  always_comb begin
    gath = '0;
    for (int k = 0; k < W; k++)
      for (int w = 0; w < W; w++)
        if (cfg[w] && int'(rank[w]) == k && link_rx[w]) gath[k] = 1'b1;
    wide   = {{N{1'b0}}, gath} << (int'(rx_beat) * int'(hcnt));
    placed = wide[N-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
      sending <= 1'b0;
      tx_beat <= '0;
      tx_sh <= '0;
    end else begin
      if (cfg_strobe && !busy) cfg <= diag;
      if (tx_valid && tx_ready) begin
        sending <= 1'b1;
        tx_beat <= '0;
        tx_sh   <= {{R{1'b0}}, tx_data};
      end else if (sending) begin
        if (tx_beat == nb - 1'b1) sending <= 1'b0;
        else begin
          tx_beat <= tx_beat + 1'b1;
          tx_sh   <= tx_sh >> hcnt;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_beat <= '0;
      acc <= '0;
      rx_valid_q <= 1'b0;
      rx_data_q <= '0;
    end else begin
      if (rx_valid_q && rx_ready) rx_valid_q <= 1'b0;
      if (link_rx_vld) begin
        if (rx_beat == nb - 1'b1) begin
          rx_valid_q <= 1'b1;
          rx_data_q  <= (rx_beat == 0) ? placed : (acc | placed);
          rx_beat    <= '0;
        end else begin
          acc     <= (rx_beat == 0) ? placed : (acc | placed);
          rx_beat <= rx_beat + 1'b1;
        end
      end
    end
  end

  assert_fail_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_failed |-> !tx_ready);
  assert_dead_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (link_tx & ~cfg) == '0);
  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg));
  assert_hold_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  assert_beat_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sending |-> (tx_beat < nb));
  assert_word_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sending || rx_valid) |-> !tx_ready);
endmodule

// File: tb/tb_adaptive_serial_link.sv
module tb_adaptive_serial_link;
  localparam int N = 16, R = 2, W = N + R, MLIMIT = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 6;
  localparam logic [W-1:0] VD [NV] = '{18'h3FFFF, 18'h2FFDF, 18'h0AAAA,
                                      18'h24111, 18'h30003, 18'h1FC00};
  localparam logic [N-1:0] VW [NV] = '{16'hA5C3, 16'h1234, 16'hBEEF,
                                      16'h8001, 16'hF00F, 16'h5A5A};
  localparam int VB [NV] = '{1, 1, 2, 4, 4, 3};
  localparam logic [W-1:0] JUNK = 18'h2D6B5;

  logic clk = 0, rst_n = 0, cfg_strobe = 0, tx_valid = 0, rx_ready = 1;
  logic [W-1:0] diag = '0, cur_diag = '0;
  logic [N-1:0] tx_data = '0, rx_data;
  logic tx_ready, link_tx_vld, rx_valid, link_failed, busy;
  logic [W-1:0] link_tx, link_rx;
  int checks = 0, errors = 0;
  bit done = 0;

  assign link_rx = link_tx | (JUNK & ~cur_diag);

  adaptive_serial_link #(.N(N), .R(R), .MLIMIT(MLIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_strobe(cfg_strobe), .diag(diag),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .link_tx(link_tx), .link_tx_vld(link_tx_vld), .link_rx(link_rx),
    .link_rx_vld(link_tx_vld), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .link_failed(link_failed), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_beat(input logic [W-1:0] d, input logic [N-1:0] x, input int b);
    int h = $countones(d), k = 0, idx;
    logic [W-1:0] v = '0;
    for (int w = 0; w < W; w++)
      if (d[w]) begin
        idx = b * h + k;
        v[w] = (idx < N) ? x[idx] : 1'b0;
        k++;
      end
    return v;
  endfunction

  task automatic configure(input logic [W-1:0] d);
    @(negedge clk); diag = d; cfg_strobe = 1;
    @(negedge clk); cfg_strobe = 0; cur_diag = d;
  endtask

  task automatic send_word(input logic [N-1:0] x, input int exp_nb, input bit take);
    int nbt = 0;
    bit pat_ok = 1;
    @(negedge clk);
    chk(tx_ready, "R3 ready when healthy", tx_ready, 1);
    tx_valid = 1; tx_data = x;
    @(negedge clk); tx_valid = 0;
    rx_ready = take;
    while (link_tx_vld && nbt < 32) begin
      if (link_tx !== exp_beat(cur_diag, x, nbt)) begin
        pat_ok = 0;
        chk(0, "R5 beat packing", link_tx, exp_beat(cur_diag, x, nbt));
      end
      if ((link_tx & ~cur_diag) != 0) chk(0, "R4 dead wire driven", link_tx, 0);
      chk(busy, "R9 busy while sending", busy, 1);
      nbt++;
      @(negedge clk);
    end
    chk(pat_ok, "R5 all beats packed", pat_ok, 1);
    chk(nbt == exp_nb, "R6 beat count", nbt, exp_nb);
    chk(rx_valid && rx_data == x, "R7 rebuilt word", rx_data, x);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(link_failed && !tx_ready && !rx_valid && !busy && !link_tx_vld, "R1 reset state",
        {link_failed, tx_ready, rx_valid, busy, link_tx_vld}, 5'b10000);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      configure(VD[i]);
      chk(!link_failed, "R3 healthy config", link_failed, 0);
      send_word(VW[i], VB[i], 1);
      @(negedge clk);
      chk(!rx_valid && !busy, "R9 idle after take", {rx_valid, busy}, 0);
    end

    // R3: three healthy wires -> failed, nothing accepted
    configure(18'h00007);
    chk(link_failed, "R3 below limit", link_failed, 1);
    tx_valid = 1; tx_data = 16'hFFFF;
    repeat (4) begin
      @(negedge clk);
      chk(!tx_ready && !link_tx_vld, "R3 no word accepted", {tx_ready, link_tx_vld}, 0);
    end
    tx_valid = 0;

    // R8 + R2: hold word, strobe while busy must be ignored
    configure(18'h0AAAA);
    send_word(16'hC0DE, 2, 0);
    diag = 18'h00001; cfg_strobe = 1;
    @(negedge clk); cfg_strobe = 0;
    tx_valid = 1; tx_data = 16'h7777;
    repeat (3) begin
      chk(rx_valid && rx_data == 16'hC0DE, "R8 hold pending", rx_data, 16'hC0DE);
      chk(!tx_ready && busy, "R8 stall at boundary", {tx_ready, busy}, 2'b01);
      @(negedge clk);
    end
    tx_valid = 0;
    rx_ready = 1;
    @(negedge clk);
    chk(!link_failed, "R2 strobe while busy ignored", link_failed, 0);
    send_word(16'h3C96, 2, 1);

    // R6: back-to-back word after all healthy config
    @(negedge clk);
    configure(18'h3FFFF);
    send_word(16'h0F0F, 1, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule